// File: doc/BRIEF.md
# End-of-Interrupt Retirement Unit

This block is the retirement side of a per-CPU interrupt controller. It keeps a 256-entry in-service vector set and a matching 256-entry trigger-mode set, both held as eight 32-bit words, and a 32-bit spurious/control register. When software writes the end-of-interrupt strobe, the block retires the highest-numbered vector that is in service and clears it. If that vector was level-triggered and directed mode is off, the block sends a one-cycle notification carrying the vector number to the downstream I/O interrupt routers. The routers use it to re-arm the line.

Accepting new interrupts is not part of this block. A plain set port marks a vector as in service and records its trigger mode. The outputs to the CPU side are an interrupt-active flag and the highest in-service vector. Both are taken from the in-service set as it stands after each update.

A two-state machine sequences the retirement. The states are `ST_IDLE` (no notification in flight) and `ST_RETIRE` (the cycle after an accepted strobe, in which the notification may be shown). The transitions are:
- IDLE→RETIRE when a strobe arrives with at least one vector in service.
- IDLE→IDLE when a strobe arrives with nothing in service. The strobe is ignored.
- RETIRE→RETIRE when another strobe is accepted back to back.
- RETIRE→IDLE when no strobe is accepted.

Top module: `lic_eoi_unit`

## Requirements
- R1: After reset the in-service set is empty, `bcast_valid` is 0, `cpu_irq` is 0 and `cpu_top_vec` is 0. The control register resets to 0x000000FF, so bit 8 is 0 and bit 12 is 0.
- R2: A cycle with `isr_set_valid`=1 marks vector `isr_set_vec` as in service. In the same cycle its trigger mode is recorded from `isr_set_level` (1 = level, 0 = edge). `cpu_top_vec` shows the highest in-service vector from the next cycle on.
- R3: A cycle with `eoi_wr`=1 and a non-empty in-service set retires the highest-numbered in-service vector and clears it. From the next cycle `cpu_top_vec` shows the next lower in-service vector, or 0 if none remain.
- R4: A retired vector whose trigger mode is level produces `bcast_valid`=1 for exactly the one cycle after the strobe, with `bcast_vec` equal to that vector. An edge-mode vector produces no pulse.
- R5: While control bit 12 (directed mode) is 1, no retirement produces a pulse, even for a level vector. The vector is still cleared.
- R6: A strobe while the in-service set is empty changes nothing and produces no pulse.
- R7: `cpu_irq` equals control bit 8 (software enable) ANDed with "in-service set non-empty". It is re-evaluated after every set and every retirement.
- R8: A control write (`spur_wr`=1, value `spur_wdata`) takes effect from the next cycle. A strobe in the same cycle as the write uses the old bit 12.
- R9: Strobes in consecutive cycles each retire one vector, in descending order. Each produces its own one-cycle pulse.
- R10: When a set and a strobe arrive in the same cycle, the strobe picks from the in-service set as it was before that cycle. The set is still applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| isr_set_valid | input | 1 | Mark a vector in service |
| isr_set_vec | input | 8 | Vector to mark |
| isr_set_level | input | 1 | Trigger mode of that vector (1 = level) |
| spur_wr | input | 1 | Control register write strobe |
| spur_wdata | input | 32 | Control register write value (bit 8 enable, bit 12 directed mode) |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| bcast_valid | output | 1 | One-cycle notification to I/O routers |
| bcast_vec | output | 8 | Vector carried by the notification |
| cpu_irq | output | 1 | Interrupt-active indication to the CPU |
| cpu_top_vec | output | 8 | Highest in-service vector (0 when none) |

## Verification
The bench builds the block with its default parameters: 256 vectors in 32-bit words, which gives eight words. These defaults put both extreme vectors, 0 and 255, within reach. They also let the priority search cross every word boundary. With vectors spread over several words, the bench checks that retirement always picks the top word before the bit within it. The bench also covers back-to-back strobes, a control write in the same cycle as a strobe, and a set in the same cycle as a strobe.

// File: rtl/lic_eoi_pkg.sv
package lic_eoi_pkg;

    // Retirement sequencer states
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RETIRE = 1'b1
    } eoi_state_e;

    // Control register field positions (software visible)
    localparam int SPUR_EN_BIT  = 8;
    localparam int SPUR_DIR_BIT = 12;
    localparam logic [31:0] SPUR_RESET = 32'h0000_00FF;

endpackage

// File: rtl/lic_prio_find.sv
// Highest-set-bit search, split into per-word searches and a word selector.
module lic_prio_find #(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    localparam int VW  = $clog2(NUM_VEC),
    localparam int WW  = $clog2(WORD_W),
    localparam int NW  = NUM_VEC / WORD_W,
    localparam int NWW = VW - WW
) (
    input  logic [NUM_VEC-1:0] bits_in,
    output logic               any_set,
    output logic [VW-1:0]      top_idx
);

    logic [NW-1:0]    word_any;
    logic [NW*WW-1:0] word_idx_flat;
    logic [NWW-1:0]   word_sel;
    logic [WW-1:0]    bit_sel;

    for (genvar g = 0; g < NW; g++) begin : g_word
        logic [WW-1:0] loc_idx;
        always_comb begin
            loc_idx = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits_in[g*WORD_W + b]) loc_idx = WW'(b);
            end
        end
        assign word_any[g] = |bits_in[g*WORD_W +: WORD_W];
        assign word_idx_flat[g*WW +: WW] = loc_idx;
    end

    always_comb begin
        word_sel = '0;
        for (int w = 0; w < NW; w++) begin
            if (word_any[w]) word_sel = NWW'(w);
        end
        bit_sel = word_idx_flat[word_sel*WW +: WW];
    end

    assign any_set = |word_any;
    assign top_idx = {word_sel, bit_sel};

endmodule

// File: rtl/lic_vec_store.sv
// In-service and trigger-mode vector sets. A set in the same cycle wins over a clear.
module lic_vec_store #(
    parameter int NUM_VEC = 256,
    localparam int VW = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [VW-1:0]      set_vec,
    input  logic               set_level,
    input  logic               clr_en,
    input  logic [VW-1:0]      clr_vec,
    output logic [NUM_VEC-1:0] isr_bits,
    output logic [NUM_VEC-1:0] tmr_bits
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_bits <= '0;
            tmr_bits <= '0;
        end else begin
            if (clr_en) isr_bits[clr_vec] <= 1'b0;
            if (set_en) begin
                isr_bits[set_vec] <= 1'b1;
                tmr_bits[set_vec] <= set_level;
            end
        end
    end

endmodule

// File: rtl/lic_eoi_fsm.sv
// Retirement sequencer: accepts the strobe and drives the router notification.
module lic_eoi_fsm
    import lic_eoi_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eoi_wr,
    input  logic          isr_any,
    input  logic [VW-1:0] top_vec,
    input  logic          top_level,
    input  logic          dir_mode,
    output logic          clr_en,
    output logic [VW-1:0] clr_vec,
    output logic          bcast_valid,
    output logic [VW-1:0] bcast_vec
);

    eoi_state_e state_q, state_d;
    logic       accept;
    logic       notify_q;
    logic [VW-1:0] vec_q;

    assign accept  = eoi_wr && isr_any;
    assign clr_en  = accept;
    assign clr_vec = top_vec;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = accept ? ST_RETIRE : ST_IDLE;
            ST_RETIRE: state_d = accept ? ST_RETIRE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            notify_q <= 1'b0;
            vec_q    <= '0;
        end else if (accept) begin
            notify_q <= top_level && !dir_mode;
            vec_q    <= top_vec;
        end else begin
            notify_q <= 1'b0;
        end
    end

    assign bcast_valid = (state_q == ST_RETIRE) && notify_q;
    assign bcast_vec   = vec_q;

endmodule

// File: rtl/lic_eoi_unit.sv
module lic_eoi_unit
    import lic_eoi_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    localparam int VW = $clog2(NUM_VEC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          isr_set_valid,
    input  logic [VW-1:0] isr_set_vec,
    input  logic          isr_set_level,
    input  logic          spur_wr,
    input  logic [31:0]   spur_wdata,
    input  logic          eoi_wr,
    output logic          bcast_valid,
    output logic [VW-1:0] bcast_vec,
    output logic          cpu_irq,
    output logic [VW-1:0] cpu_top_vec
);

    logic [31:0]        spur_q;
    logic [NUM_VEC-1:0] isr_bits;
    logic [NUM_VEC-1:0] tmr_bits;
    logic               isr_any;
    logic [VW-1:0]      top_vec;
    logic               clr_en;
    logic [VW-1:0]      clr_vec;
    logic               spur_unused;

    always_ff @(posedge clk) begin
        if (!rst_n)       spur_q <= SPUR_RESET;
        else if (spur_wr) spur_q <= spur_wdata;
    end

    assign spur_unused = ^{spur_q[31:13], spur_q[11:9], spur_q[7:0]};

    lic_vec_store #(.NUM_VEC(NUM_VEC)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (isr_set_valid),
        .set_vec   (isr_set_vec),
        .set_level (isr_set_level),
        .clr_en    (clr_en),
        .clr_vec   (clr_vec),
        .isr_bits  (isr_bits),
        .tmr_bits  (tmr_bits)
    );

    lic_prio_find #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_find (
        .bits_in (isr_bits),
        .any_set (isr_any),
        .top_idx (top_vec)
    );

    lic_eoi_fsm #(.VW(VW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .eoi_wr      (eoi_wr),
        .isr_any     (isr_any),
        .top_vec     (top_vec),
        .top_level   (tmr_bits[top_vec]),
        .dir_mode    (spur_q[SPUR_DIR_BIT]),
        .clr_en      (clr_en),
        .clr_vec     (clr_vec),
        .bcast_valid (bcast_valid),
        .bcast_vec   (bcast_vec)
    );

    assign cpu_irq     = spur_q[SPUR_EN_BIT] && isr_any;
    assign cpu_top_vec = top_vec;

endmodule

// File: rtl/lic_eoi_checker.sv
module lic_eoi_checker #(
    parameter int VW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          eoi_wr,
    input logic          isr_set_valid,
    input logic          isr_any,
    input logic          dir_mode,
    input logic          bcast_valid,
    input logic [VW-1:0] bcast_vec,
    input logic [VW-1:0] cpu_top_vec
);

    AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_valid |-> $past(eoi_wr)); // R4

    AST_PULSE_CARRIES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && isr_any) |=> (!bcast_valid || bcast_vec == $past(cpu_top_vec))); // R4

    AST_EMPTY_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !isr_any) |=> !bcast_valid); // R6

    AST_DIRECTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && dir_mode) |=> !bcast_valid); // R5

    AST_TOP_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && isr_any && !isr_set_valid) |=>
            (!isr_any || cpu_top_vec < $past(cpu_top_vec))); // R3

endmodule

bind lic_eoi_unit lic_eoi_checker #(.VW(VW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .eoi_wr        (eoi_wr),
    .isr_set_valid (isr_set_valid),
    .isr_any       (isr_any),
    .dir_mode      (spur_q[12]),
    .bcast_valid   (bcast_valid),
    .bcast_vec     (bcast_vec),
    .cpu_top_vec   (cpu_top_vec)
);

// File: tb/lic_eoi_unit_test.sv
`timescale 1ns/1ps
module lic_eoi_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       isr_set_valid = 1'b0;
    logic [7:0] isr_set_vec = '0;
    logic       isr_set_level = 1'b0;
    logic       spur_wr = 1'b0;
    logic [31:0] spur_wdata = '0;
    logic       eoi_wr = 1'b0;
    logic       bcast_valid;
    logic [7:0] bcast_vec;
    logic       cpu_irq;
    logic [7:0] cpu_top_vec;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    bit [255:0] m_isr = '0;
    bit [255:0] m_tmr = '0;
    bit [31:0]  m_spur = 32'h0000_00FF;
    int         exp_q[$];

    always #2.5 clk = ~clk;

    lic_eoi_unit uut (
        .clk(clk), .rst_n(rst_n),
        .isr_set_valid(isr_set_valid), .isr_set_vec(isr_set_vec),
        .isr_set_level(isr_set_level),
        .spur_wr(spur_wr), .spur_wdata(spur_wdata), .eoi_wr(eoi_wr),
        .bcast_valid(bcast_valid), .bcast_vec(bcast_vec),
        .cpu_irq(cpu_irq), .cpu_top_vec(cpu_top_vec)
    );

    function automatic int model_top(bit [255:0] s);
        for (int i = 255; i >= 0; i--) if (s[i]) return i;
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: drives one cycle (called at a negedge), updates model, pushes expected pulses.
    task automatic step(bit do_set, int sv, bit lvl, bit do_cfg, bit [31:0] cv, bit do_eoi);
        isr_set_valid = do_set;
        isr_set_vec   = 8'(sv);
        isr_set_level = lvl;
        spur_wr       = do_cfg;
        spur_wdata    = cv;
        eoi_wr        = do_eoi;
        if (do_eoi && (m_isr != '0)) begin
            int t = model_top(m_isr);
            if (m_tmr[t] && !m_spur[12]) exp_q.push_back(t);
            m_isr[t] = 1'b0;
        end
        if (do_set) begin
            m_isr[sv] = 1'b1;
            m_tmr[sv] = lvl;
        end
        if (do_cfg) m_spur = cv;
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 32'h0, 0);
    endtask

    task automatic check_outs(string tag);
        check({tag, " cpu_top_vec"}, cpu_top_vec, model_top(m_isr));
        check({tag, " cpu_irq"}, cpu_irq, int'(m_spur[8] && (m_isr != '0)));
    endtask

    // Monitor: pops expected notifications as the design produces them.
    always @(negedge clk) begin
        if (rst_n && bcast_valid) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected bcast_vec", bcast_vec, -1);
            end else begin
                check("R4 bcast_vec", bcast_vec, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 bcast_valid", bcast_valid, 0);
        check("R1 cpu_irq", cpu_irq, 0);
        check("R1 cpu_top_vec", cpu_top_vec, 0);

        // R2 / R7: set with software enable off keeps cpu_irq low
        step(1, 5, 0, 0, 32'h0, 0);
        check_outs("R2 R7 enable off");
        step(0, 0, 0, 1, 32'h0000_01FF, 0);
        check_outs("R7 enable on");

        // R2 sets across words, both extremes
        step(1, 200, 1, 0, 32'h0, 0);
        step(1, 37, 0, 0, 32'h0, 0);
        step(1, 255, 1, 0, 32'h0, 0);
        step(1, 0, 1, 0, 32'h0, 0);
        check_outs("R2 after sets");

        // R3 / R4 retire in descending order, level only notifies
        for (int k = 0; k < 5; k++) begin
            step(0, 0, 0, 0, 32'h0, 1);
            idle();
            check_outs("R3 retire");
        end
        check("R3 empty after retire", cpu_irq, 0);

        // R6 strobe on empty set
        step(0, 0, 0, 0, 32'h0, 1);
        idle();
        check("R6 bcast_valid", bcast_valid, 0);
        check_outs("R6 no change");

        // R5 directed mode suppresses
        step(0, 0, 0, 1, 32'h0000_11FF, 0);
        step(1, 100, 1, 0, 32'h0, 0);
        step(0, 0, 0, 0, 32'h0, 1);
        check("R5 bcast_valid", bcast_valid, 0);
        idle();
        check_outs("R5 cleared");

        // R8 same-cycle control write uses the old directed bit
        step(1, 101, 1, 0, 32'h0, 0);
        step(0, 0, 0, 1, 32'h0000_01FF, 1);
        check("R8 old directed bit", bcast_valid, 0);
        step(1, 102, 1, 0, 32'h0, 0);
        step(0, 0, 0, 0, 32'h0, 1);
        check("R8 new directed bit", bcast_valid, 1);
        idle();

        // R9 back-to-back strobes
        step(1, 10, 1, 0, 32'h0, 0);
        step(1, 20, 1, 0, 32'h0, 0);
        step(1, 30, 1, 0, 32'h0, 0);
        step(0, 0, 0, 0, 32'h0, 1);
        step(0, 0, 0, 0, 32'h0, 1);
        step(0, 0, 0, 0, 32'h0, 1);
        idle();
        check_outs("R9 back to back");

        // R10 set and strobe together
        step(1, 50, 1, 0, 32'h0, 0);
        step(1, 60, 1, 0, 32'h0, 1);
        idle();
        check_outs("R10 set with strobe");
        step(0, 0, 0, 0, 32'h0, 1);
        idle();

        // Mixed pattern over all words
        for (int i = 1; i <= 24; i++) step(1, (i * 37) % 256, i[0], 0, 32'h0, 0);
        check_outs("R2 mixed sets");
        while (m_isr != '0) begin
            step(0, 0, 0, 0, 32'h0, 1);
            check_outs("R3 mixed retire");
        end
        idle();
        idle();
        check("R4 all notifications seen", exp_q.size(), 0);
        check("R7 final cpu_irq", cpu_irq, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule